// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of a successive approximation analog-to-digital converter. A start pulse begins a conversion. The block then drives a trial code to an external DAC and reads one comparator bit back on every clock. It decides one bit of the code per clock, from the most significant bit down to the least significant bit. When the last bit is settled it raises a one-cycle completion flag and presents the final code on a result port.

A one-hot ring pointer marks the bit under trial. On each clock the controller does three things: it keeps or clears the marked bit according to the comparator level, it sets the next lower bit as the new trial, and it moves the pointer down one place. A conversion of an N-bit code therefore ends exactly N clocks after the start is accepted. While a conversion is running, further start pulses have no effect. The comparator is expected to settle within one clock of a trial code change.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A start pulse seen while idle makes the trial code equal to only the MSB set (1 followed by zeros) on the next clock, and busy goes high on that same clock.
- R2: While busy, a high comparator level (DAC output below the input) keeps the bit under trial at 1.
- R3: While busy, a low comparator level (DAC output above the input) clears the bit under trial to 0.
- R4: On the same clock that a bit is decided, the next lower bit is set to 1 as the new trial, and all bits below it stay 0.
- R5: The pointer to the bit under trial is one-hot while busy. It starts at the MSB and moves one place toward the LSB on each clock.
- R6: Done is high for exactly one cycle, on the N-th clock after the start was accepted, and busy falls on that same clock.
- R7: The result port takes the final code on the clock done rises and keeps it until the next conversion completes. When the comparator is high whenever the trial code is at most the input value, the result equals that input value.
- R8: A start pulse that arrives while busy is ignored. The running conversion neither restarts nor lengthens.
- R9: After reset, busy, done, the trial code and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a conversion (acted on only when idle) |
| cmp_i | input | 1 | Comparator level: 1 when the DAC output is below the input |
| trial_code_o | output | WIDTH | Code currently driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when the final code is ready |
| result_o | output | WIDTH | Final code of the last completed conversion |

## Verification
The assertions check, on every cycle, the per-clock mechanics: the MSB-only load at start, the keep or clear of the marked bit and the setting of the next lower one, the one-hot pointer stepping down, the single-cycle done, and the rule that the result changes only when done is high. Only the bench scenarios can show the end-to-end outcome. These include the final code equal to the input value over the whole 8-bit input range, the N-clock latency measured from the ports, the full trial-code sequence of every conversion, and a start pulse injected mid-conversion leaving that conversion unchanged.

// File: rtl/sar_ctrl_pkg.sv
// Package: shared types for the successive approximation controller.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable types.
package sar_ctrl_pkg;

    // Conversion sequencer states.
    typedef enum logic {
        CONV_IDLE = 1'b0,
        CONV_RUN  = 1'b1
    } conv_state_t;

endpackage

// File: rtl/sar_bit_ring.sv
// Module: one-hot ring pointer marking the bit under trial.
// Loads the MSB position on load_i and rotates one place toward the LSB on
// every advance_i. last_o flags that the LSB is marked.
// Assumes: load_i and advance_i are never high together.
module sar_bit_ring #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             advance_i,
    output logic [WIDTH-1:0] ptr_o,
    output logic             last_o
);

    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] ptr_q;

    // Pointer register: load the MSB, or rotate toward the LSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load_i) begin
            ptr_q <= MSB_ONLY;
        end else if (advance_i) begin
            ptr_q <= {ptr_q[0], ptr_q[WIDTH-1:1]};
        end
    end

    assign ptr_o  = ptr_q;
    assign last_o = ptr_q[0];

    // While stepping, the pointer holds exactly one marked bit.
    AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i |-> ($countones(ptr_q) == 1)); // R5

    // Each non-final step moves the mark one place down.
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !ptr_q[0]) |=> (ptr_q == ($past(ptr_q) >> 1))); // R5

endmodule

// File: rtl/sar_trial_reg.sv
// Module: trial code register with a per-bit decide-and-advance slice.
// On load_i the code becomes MSB-only. On step_i the bit marked by sel_i
// takes the comparator level and the bit just below it is set as new trial.
// next_o is the value the register takes on the coming edge.
// Assumes: sel_i is one-hot whenever step_i is high.
module sar_trial_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] sel_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] code_o,
    output logic [WIDTH-1:0] next_o
);

    logic [WIDTH-1:0] code_q;
    logic [WIDTH-1:0] code_d;

    // One slice per bit: load value, decision, or next-trial set.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        logic below_mark;
        if (gi == WIDTH-1) begin : g_top
            assign below_mark = 1'b0;
        end else begin : g_rest
            assign below_mark = sel_i[gi+1];
        end

        // Next value of this bit for the coming edge.
        always_comb begin
            if (load_i) begin
                code_d[gi] = (gi == WIDTH-1);
            end else if (step_i && sel_i[gi]) begin
                code_d[gi] = cmp_i;
            end else if (step_i && below_mark) begin
                code_d[gi] = 1'b1;
            end else begin
                code_d[gi] = code_q[gi];
            end
        end
    end

    // Code register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    assign code_o = code_q;
    assign next_o = code_d;

    // A start loads the MSB-only trial.
    AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (code_q == {1'b1, {(WIDTH-1){1'b0}}})); // R1

    // High comparator keeps the marked bit.
    AST_KEEP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && cmp_i) |=> ((code_q & $past(sel_i)) == $past(sel_i))); // R2

    // Low comparator clears the marked bit.
    AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !cmp_i) |=> ((code_q & $past(sel_i)) == '0)); // R3

    // The bit below the decided one becomes the new trial.
    AST_NEXT_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !sel_i[0]) |=> ((code_q & ($past(sel_i) >> 1)) == ($past(sel_i) >> 1))); // R4

endmodule

// File: rtl/sar_conv_seq.sv
// Module: conversion sequencer (idle / run) with the done pulse.
// Accepts start only in idle, runs until the pointer reports the LSB, then
// returns to idle and pulses done for one cycle.
// Assumes: last_i is valid on the clock the LSB is decided.
module sar_conv_seq
    import sar_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic last_i,
    output logic load_o,
    output logic step_o,
    output logic finish_o,
    output logic busy_o,
    output logic done_o
);

    conv_state_t state_q;
    conv_state_t state_d;
    logic        done_q;

    assign load_o   = (state_q == CONV_IDLE) && start_i;
    assign step_o   = (state_q == CONV_RUN);
    assign finish_o = step_o && last_i;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CONV_IDLE: if (start_i) state_d = CONV_RUN;
            CONV_RUN:  if (last_i)  state_d = CONV_IDLE;
            default:   state_d = CONV_IDLE;
        endcase
    end

    // State and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CONV_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish_o;
        end
    end

    assign busy_o = (state_q == CONV_RUN);
    assign done_o = done_q;

    // Done never lasts more than one cycle.
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R6

    // Done coincides with busy falling.
    AST_DONE_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_o && $past(busy_o))); // R6

    // A start while running does not end or restart the run early.
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !last_i) |=> (busy_o && !done_q)); // R8

endmodule

// File: rtl/sar_conv_ctrl.sv
// Module: successive approximation conversion controller (top).
// Drives an N-bit trial code to an external DAC, decides one bit per clock
// from the comparator level, and presents the final code with a done pulse.
// Assumes: cmp_i settles within one clock of a trial code change.
module sar_conv_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] trial_code_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);

    logic             load;
    logic             step;
    logic             finish;
    logic             last;
    logic [WIDTH-1:0] ptr;
    logic [WIDTH-1:0] code_next;
    logic [WIDTH-1:0] result_q;

    sar_conv_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .last_i   (last),
        .load_o   (load),
        .step_o   (step),
        .finish_o (finish),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    sar_bit_ring #(.WIDTH(WIDTH)) i_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .advance_i (step),
        .ptr_o     (ptr),
        .last_o    (last)
    );

    sar_trial_reg #(.WIDTH(WIDTH)) i_trial (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step),
        .sel_i   (ptr),
        .cmp_i   (cmp_i),
        .code_o  (trial_code_o),
        .next_o  (code_next)
    );

    // Result register: capture the fully decided code at the LSB decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (finish) begin
            result_q <= code_next;
        end
    end

    assign result_o = result_q;

    // The result only changes on the cycle done is shown.
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o); // R7

    // At done the result matches the trial code left in the register.
    AST_RESULT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o == trial_code_o)); // R7

endmodule

// File: tb/test_sar_conv_ctrl.sv
// Bench: exhaustive sweep of all 8-bit input values with a modelled
// comparator, plus strict-compare, mid-run start and reset scenarios.
module test_sar_conv_ctrl;

    localparam int  N        = 8;
    localparam time CLK_T    = 10ns;
    localparam int  WDOG_MAX = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp;
    logic [N-1:0] trial;
    logic         busy;
    logic         done;
    logic [N-1:0] result;

    logic [N-1:0] vin = '0;
    logic         strict = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    // Comparator model: high when the DAC code is below (or at) the input.
    always_comb cmp = strict ? (trial < vin) : (trial <= vin);

    sar_conv_ctrl #(.WIDTH(N)) i_sar_conv_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .cmp_i        (cmp),
        .trial_code_o (trial),
        .busy_o       (busy),
        .done_o       (done),
        .result_o     (result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Expected final code for a given input and comparator mode.
    function automatic int expect_code(input int v, input bit s);
        if (s) return (v == 0) ? 0 : v - 1;
        return v;
    endfunction

    // Run one conversion; optional start pulse injected after inj_at samples.
    task automatic convert(input int v, input bit s, input int inj_at);
        int cnt;
        int exp_final;
        int decided;
        vin    = v[N-1:0];
        strict = s;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R1: MSB-only trial and busy right after the start edge
        check(trial == (1 << (N-1)), "R1", trial, 1 << (N-1));
        check(busy == 1'b1, "R1", busy, 1);
        exp_final = expect_code(v, s);
        cnt = 0;
        while (!done && cnt <= N + 2) begin
            // R2 R3 R4 R5: after cnt decisions, upper bits equal final code
            // and the next lower bit is the trial
            if (cnt > 0 && cnt < N) begin
                decided = exp_final & ~((1 << (N - cnt)) - 1);
                check(trial == (decided | (1 << (N - 1 - cnt))), "R4", trial,
                      decided | (1 << (N - 1 - cnt)));
            end
            if (cnt == inj_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cnt++;
        end
        // R6: done exactly N clocks after the start edge; busy low with it
        check(cnt == N, "R6", cnt, N);
        check(busy == 1'b0, "R6", busy, 0);
        // R7 R2 R3: final code equals the input (or input-1 for strict compare)
        check(result == exp_final, "R7", result, exp_final);
        @(negedge clk);
        check(done == 1'b0, "R6", done, 0);
        // R8: injected start did not relaunch a conversion
        if (inj_at >= 0) check(busy == 1'b0, "R8", busy, 0);
        check(result == exp_final, "R7", result, exp_final);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int c = 0; c < WDOG_MAX; c++) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", WDOG_MAX, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(busy == 1'b0, "R9", busy, 0);
        check(done == 1'b0, "R9", done, 0);
        check(trial == '0, "R9", trial, 0);
        check(result == '0, "R9", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R9", busy, 0);

        // Exhaustive sweep, inclusive compare: result equals input.
        for (int v = 0; v < (1 << N); v++) convert(v, 1'b0, -1);

        // Strict compare: every low comparator answer clears the bit.
        for (int v = 0; v < (1 << N); v += 17) convert(v, 1'b1, -1);

        // R8: start pulses injected at several points of a running conversion.
        for (int k = 0; k < N; k++) convert(8'hA5 ^ k, 1'b0, k);

        // R7: result holds through idle cycles and through the next run.
        convert(8'h3C, 1'b0, -1);
        repeat (5) @(negedge clk);
        check(result == 8'h3C, "R7", result, 8'h3C);
        vin   = 8'hC3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(result == 8'h3C, "R7", result, 8'h3C);
        while (!done) @(negedge clk);
        check(result == 8'hC3, "R7", result, 8'hC3);

        @(negedge clk);
        finish_run();
    end

endmodule